// File: doc/BRIEF.md
# I2C bus stuck-low recovery controller

This block sits between an I2C/SMBus host controller and the open-drain SCL and SDA pads. While no transfer is granted it watches the two lines through a two-flop synchronizer. When a target keeps SDA low while SCL floats high for longer than a debounce window, the bus is treated as hung. That normally happens when a target lost clock sync or saw a reset mid-transfer and still believes it owns an acknowledge bit.

Recovery does not pulse extra clocks, because a target may then finish the earlier transfer with its bits shifted by one. Instead the block pulls SCL low without a break for a long timeout (35 ms by default), so every target aborts. It then releases SCL and waits a bounded time for both lines to read high. Success gives a one-cycle done pulse and returns the bus to the idle state, where a new start condition can be issued. A timeout sets a sticky failure flag, increments a saturating error counter and starts another hold, up to a set number of retries.

The host asks for the bus with a request and may drive the pads only while the grant is high. During a granted transfer the host's pull-down requests pass straight to the pads, so normal 100 kHz traffic is not disturbed. All time windows are given in microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `i2c_bus_rescue`

## Requirements
- R1: While reset is high and in the first cycle after it, host_grant, scl_oe, sda_oe, recovering, recovery_done and recovery_failed are 0 and err_count is 0.
- R2: bus_ready is 1 exactly when no transfer is granted, no recovery runs, and both synchronized lines are high. The synchronized lines follow scl_in and sda_in two clock edges late.
- R3: If host_req and bus_ready are both 1 in a cycle, host_grant is 1 from the next cycle on. It stays 1 while host_req stays 1 and falls in the cycle after the cycle in which host_req is 0.
- R4: While host_grant is 1, scl_oe equals host_scl_oe and sda_oe equals host_sda_oe in the same cycle. A 1 on an enable means the pad is pulled low, and the pads are never driven high. When host_grant is 0, sda_oe is 0.
- R5: A hang is declared only after the synchronized lines show SCL high and SDA low for DEBOUNCE_US worth of consecutive cycles while no transfer is granted. Any cycle with SCL low or SDA high restarts that count. recovering rises when the hang is declared.
- R6: Each recovery attempt holds scl_oe at 1 without a break for exactly HOLD_US worth of cycles (35 ms by default). It then drops scl_oe to 0.
- R7: After the hold, the block waits up to SETTLE_US worth of cycles for both synchronized lines to be high. In the first cycle they are, recovering falls in the next cycle, recovery_done is 1 for exactly that one cycle, and the block returns to watching.
- R8: If the settle window expires with a line still low, recovery_failed becomes 1 and stays 1 until reset. err_count rises by one (saturating) and a new hold starts, up to RETRIES further holds. After the last failed attempt the block returns to watching.
- R9: While recovering is 1, host_grant is 0 whatever host_req does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Host asks for the bus |
| host_scl_oe | input | 1 | Host wants SCL pulled low |
| host_sda_oe | input | 1 | Host wants SDA pulled low |
| host_grant | output | 1 | Host may drive the bus |
| scl_in | input | 1 | SCL pad level |
| sda_in | input | 1 | SDA pad level |
| scl_oe | output | 1 | Pull SCL pad low |
| sda_oe | output | 1 | Pull SDA pad low |
| bus_ready | output | 1 | Both lines idle high, no grant, no recovery |
| recovering | output | 1 | Recovery hold or settle in progress |
| recovery_done | output | 1 | One-cycle pulse when the bus has recovered |
| recovery_failed | output | 1 | Sticky flag for a settle timeout |
| err_count | output | ERR_W | Saturating count of failed recovery attempts |

## Verification
Two pairs of events can land in the same cycle. In the first, a recovery completes while a host request has been waiting through the whole hold. The bench keeps host_req high across a healing recovery and checks three things: the grant stays low in the cycle of the done pulse, bus_ready is high then, and the grant rises in the cycle after. In the second, a settle timeout falls on the same edge that increments err_count and starts the next hold (or gives up after the last one). A target that never lets go drives the block through every retry, and the behavioural model judges the flag, the counter and scl_oe in that cycle and on every other clock.

// File: rtl/i2c_rescue_pkg.sv
package i2c_rescue_pkg;

    typedef int unsigned uint_t;

    // Block phases: watching the idle bus, host transfer, SCL hold, settle check.
    typedef enum logic [1:0] {
        PH_WATCH  = 2'd0,
        PH_XFER   = 2'd1,
        PH_HOLD   = 2'd2,
        PH_SETTLE = 2'd3
    } phase_e;

    // Synchronized line levels.
    typedef struct packed {
        logic scl;
        logic sda;
    } bus_t;

    // Convert a microsecond window into clock cycles, at least one.
    function automatic uint_t us_to_cycles(input uint_t hz, input uint_t us);
        logic [63:0] c;
        c = 64'(hz) / 64'd1000 * 64'(us) / 64'd1000;
        if (c == 64'd0) c = 64'd1;
        return uint_t'(c);
    endfunction

    function automatic int bits_for(input uint_t n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic uint_t max3(input uint_t a, input uint_t b, input uint_t c);
        uint_t m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/i2c_rescue_sync.sv
module i2c_rescue_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // One shift chain per line; resets to low so nothing reads idle early.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2c_rescue_ctrl.sv
module i2c_rescue_ctrl
    import i2c_rescue_pkg::*;
#(
    parameter uint_t DEB_CYC  = 100,
    parameter uint_t HOLD_CYC = 3500,
    parameter uint_t SET_CYC  = 100,
    parameter uint_t RETRIES  = 3,
    parameter int    CNT_W    = 12,
    parameter int    TRY_W    = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  bus_t   line,
    input  logic   host_req,
    output phase_e phase,
    output logic   ev_done,
    output logic   ev_fail
);
    localparam logic [CNT_W-1:0] DEB_LAST  = CNT_W'(DEB_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] SET_LAST  = CNT_W'(SET_CYC - 1);
    localparam logic [TRY_W-1:0] TRY_LAST  = TRY_W'(RETRIES);

    logic [CNT_W-1:0] cnt;
    logic [TRY_W-1:0] tries;
    logic             idle_hi;
    logic             hung;

    assign idle_hi = line.scl & line.sda;
    assign hung    = line.scl & ~line.sda;

    assign ev_done = (phase == PH_SETTLE) & idle_hi;
    assign ev_fail = (phase == PH_SETTLE) & ~idle_hi & (cnt == SET_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_WATCH;
            cnt   <= '0;
            tries <= '0;
        end else begin
            unique case (phase)
                PH_WATCH: begin
                    if (host_req && idle_hi) begin
                        phase <= PH_XFER;
                        cnt   <= '0;
                    end else if (hung) begin
                        if (cnt == DEB_LAST) begin
                            phase <= PH_HOLD;
                            cnt   <= '0;
                            tries <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end else begin
                        cnt <= '0;
                    end
                end
                PH_XFER: begin
                    if (!host_req) begin
                        phase <= PH_WATCH;
                        cnt   <= '0;
                    end
                end
                PH_HOLD: begin
                    if (cnt == HOLD_LAST) begin
                        phase <= PH_SETTLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_SETTLE: begin
                    if (idle_hi) begin
                        phase <= PH_WATCH;
                        cnt   <= '0;
                    end else if (cnt == SET_LAST) begin
                        cnt <= '0;
                        if (tries == TRY_LAST) begin
                            phase <= PH_WATCH;
                        end else begin
                            tries <= tries + TRY_W'(1);
                            phase <= PH_HOLD;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: phase <= PH_WATCH;
            endcase
        end
    end
endmodule

// File: rtl/i2c_rescue_status.sv
module i2c_rescue_status #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_done,
    input  logic             ev_fail,
    output logic             done_pulse,
    output logic             failed,
    output logic [ERR_W-1:0] errs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done_pulse <= 1'b0;
            failed     <= 1'b0;
            errs       <= '0;
        end else begin
            done_pulse <= ev_done;
            if (ev_fail) failed <= 1'b1;
            if (ev_fail && !(&errs)) errs <= errs + ERR_W'(1);
        end
    end
endmodule

// File: rtl/i2c_bus_rescue.sv
module i2c_bus_rescue
    import i2c_rescue_pkg::*;
#(
    parameter uint_t CLK_HZ      = 100_000_000,
    parameter uint_t HOLD_US     = 35_000,
    parameter uint_t DEBOUNCE_US = 1_000,
    parameter uint_t SETTLE_US   = 1_000,
    parameter uint_t RETRIES     = 3,
    parameter int    ERR_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_req,
    input  logic             host_scl_oe,
    input  logic             host_sda_oe,
    output logic             host_grant,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             bus_ready,
    output logic             recovering,
    output logic             recovery_done,
    output logic             recovery_failed,
    output logic [ERR_W-1:0] err_count
);
    localparam uint_t HOLD_CYC = us_to_cycles(CLK_HZ, HOLD_US);
    localparam uint_t DEB_CYC  = us_to_cycles(CLK_HZ, DEBOUNCE_US);
    localparam uint_t SET_CYC  = us_to_cycles(CLK_HZ, SETTLE_US);
    localparam int    CNT_W    = bits_for(max3(HOLD_CYC, DEB_CYC, SET_CYC));
    localparam int    TRY_W    = bits_for(RETRIES + 1);

    logic [1:0] sync_q;
    bus_t       line;
    phase_e     phase;
    logic       ev_done;
    logic       ev_fail;

    i2c_rescue_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (sync_q)
    );

    assign line = bus_t'(sync_q);

    i2c_rescue_ctrl #(
        .DEB_CYC  (DEB_CYC),
        .HOLD_CYC (HOLD_CYC),
        .SET_CYC  (SET_CYC),
        .RETRIES  (RETRIES),
        .CNT_W    (CNT_W),
        .TRY_W    (TRY_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .line     (line),
        .host_req (host_req),
        .phase    (phase),
        .ev_done  (ev_done),
        .ev_fail  (ev_fail)
    );

    i2c_rescue_status #(.ERR_W(ERR_W)) u_status (
        .clk        (clk),
        .rst        (rst),
        .ev_done    (ev_done),
        .ev_fail    (ev_fail),
        .done_pulse (recovery_done),
        .failed     (recovery_failed),
        .errs       (err_count)
    );

    assign host_grant = (phase == PH_XFER);
    assign scl_oe     = (phase == PH_HOLD) | (host_grant & host_scl_oe);
    assign sda_oe     = host_grant & host_sda_oe;
    assign bus_ready  = (phase == PH_WATCH) & line.scl & line.sda;
    assign recovering = (phase == PH_HOLD) | (phase == PH_SETTLE);
endmodule

// File: rtl/i2c_bus_rescue_chk.sv
module i2c_bus_rescue_chk #(
    parameter int          ERR_W    = 8,
    parameter int unsigned HOLD_CYC = 3500
) (
    input logic             clk,
    input logic             rst,
    input logic             host_req,
    input logic             host_grant,
    input logic             host_sda_oe,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             bus_ready,
    input logic             recovering,
    input logic             recovery_done,
    input logic             recovery_failed,
    input logic [ERR_W-1:0] err_count
);
    // Length of the current unbroken SCL pull during recovery.
    int unsigned hold_run;
    logic        holding;
    assign holding = recovering & scl_oe;

    always_ff @(posedge clk) begin
        if (rst)          hold_run <= 0;
        else if (holding) hold_run <= hold_run + 1;
        else              hold_run <= 0;
    end

    a_r3_grant_after_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(host_grant) |-> $past(bus_ready && host_req));

    a_r3_grant_drops: assert property (@(posedge clk) disable iff (rst)
        (host_grant && !host_req) |=> !host_grant);

    a_r4_sda_only_granted: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (host_grant && host_sda_oe));

    a_r6_hold_length: assert property (@(posedge clk) disable iff (rst)
        (!holding && $past(holding)) |-> (hold_run == HOLD_CYC));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        recovery_done |=> !recovery_done);

    a_r7_done_after_recovery: assert property (@(posedge clk) disable iff (rst)
        recovery_done |-> ($past(recovering) && !recovering));

    a_r8_failed_sticky: assert property (@(posedge clk) disable iff (rst)
        recovery_failed |=> recovery_failed);

    a_r8_errs_no_drop: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (err_count >= $past(err_count)));

    a_r9_no_grant_recovering: assert property (@(posedge clk) disable iff (rst)
        recovering |-> !host_grant);
endmodule

bind i2c_bus_rescue i2c_bus_rescue_chk #(
    .ERR_W    (ERR_W),
    .HOLD_CYC (HOLD_CYC)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .host_req        (host_req),
    .host_grant      (host_grant),
    .host_sda_oe     (host_sda_oe),
    .scl_oe          (scl_oe),
    .sda_oe          (sda_oe),
    .bus_ready       (bus_ready),
    .recovering      (recovering),
    .recovery_done   (recovery_done),
    .recovery_failed (recovery_failed),
    .err_count       (err_count)
);

// File: tb/i2c_bus_rescue_test.sv
module i2c_bus_rescue_test;
    localparam int TB_HZ   = 100_000;
    localparam int T_HOLD  = TB_HZ * 35 / 1000;   // 35 ms
    localparam int T_DEB   = TB_HZ / 1000;        // 1 ms
    localparam int T_SET   = TB_HZ / 1000;        // 1 ms
    localparam int T_RETRY = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_req = 1'b0, host_scl_oe = 1'b0, host_sda_oe = 1'b0;
    logic host_grant, scl_oe, sda_oe, bus_ready, recovering;
    logic recovery_done, recovery_failed;
    logic [7:0] err_count;
    logic scl_in, sda_in;

    // Bus environment: external SCL short and a target that may hold SDA.
    logic force_scl_low = 1'b0;
    logic tgt_stuck = 1'b0;
    logic heal = 1'b0;
    logic tgt_freed;
    int   low_run;

    assign scl_in = !scl_oe && !force_scl_low;
    assign sda_in = !sda_oe && !(tgt_stuck && !tgt_freed);

    always #5 clk = ~clk;

    // Target gives up its transfer once SCL has been low for 50 cycles.
    always @(posedge clk) begin
        if (!scl_in) low_run <= low_run + 1;
        else         low_run <= 0;
        if (!tgt_stuck)                 tgt_freed <= 1'b0;
        else if (heal && low_run >= 50) tgt_freed <= 1'b1;
    end

    i2c_bus_rescue #(.CLK_HZ(TB_HZ)) uut (
        .clk             (clk),
        .rst             (rst),
        .host_req        (host_req),
        .host_scl_oe     (host_scl_oe),
        .host_sda_oe     (host_sda_oe),
        .host_grant      (host_grant),
        .scl_in          (scl_in),
        .sda_in          (sda_in),
        .scl_oe          (scl_oe),
        .sda_oe          (sda_oe),
        .bus_ready       (bus_ready),
        .recovering      (recovering),
        .recovery_done   (recovery_done),
        .recovery_failed (recovery_failed),
        .err_count       (err_count)
    );

    int total = 0;
    int bad = 0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Behavioural reference: 0 watch, 1 transfer, 2 hold, 3 settle.
    int   mph, mcnt, mtry, merr;
    logic mfail, mdone;
    logic [1:0] qscl, qsda;

    always @(posedge clk) begin : model
        logic hi, hang;
        if (rst) begin
            mph <= 0; mcnt <= 0; mtry <= 0; merr <= 0;
            mfail <= 1'b0; mdone <= 1'b0; qscl <= 2'b00; qsda <= 2'b00;
        end else begin
            hi   = qscl[1] & qsda[1];
            hang = qscl[1] & ~qsda[1];
            qscl <= {qscl[0], scl_in};
            qsda <= {qsda[0], sda_in};
            mdone <= (mph == 3) && hi;
            case (mph)
                0: if (hi && host_req) begin mph <= 1; mcnt <= 0; end
                   else if (hang) begin
                       if (mcnt + 1 == T_DEB) begin mph <= 2; mcnt <= 0; mtry <= 0; end
                       else mcnt <= mcnt + 1;
                   end else mcnt <= 0;
                1: if (!host_req) begin mph <= 0; mcnt <= 0; end
                2: if (mcnt + 1 == T_HOLD) begin mph <= 3; mcnt <= 0; end
                   else mcnt <= mcnt + 1;
                default: if (hi) begin mph <= 0; mcnt <= 0; end
                   else if (mcnt + 1 == T_SET) begin
                       mfail <= 1'b1;
                       if (merr < 255) merr <= merr + 1;
                       mcnt <= 0;
                       if (mtry == T_RETRY) mph <= 0;
                       else begin mtry <= mtry + 1; mph <= 2; end
                   end else mcnt <= mcnt + 1;
            endcase
        end
    end

    // Compare every clock, settled well after the edge.
    always @(posedge clk) begin
        #3;
        check("R3/R9", "host_grant", host_grant, mph == 1);
        check("R6", "scl_oe", scl_oe, (mph == 2) || (mph == 1 && host_scl_oe));
        check("R4", "sda_oe", sda_oe, (mph == 1) && host_sda_oe);
        check("R2", "bus_ready", bus_ready, (mph == 0) && qscl[1] && qsda[1]);
        check("R5", "recovering", recovering, mph >= 2);
        check("R7", "recovery_done", recovery_done, mdone);
        check("R8", "recovery_failed", recovery_failed, mfail);
        check("R8", "err_count", err_count, merr);
    end

    // Length of each SCL hold seen at the pins.
    int run = 0, last_run = 0;
    always @(negedge clk) begin
        if (recovering && scl_oe) run <= run + 1;
        else begin
            if (run > 0) last_run <= run;
            run <= 0;
        end
    end

    initial begin
        repeat (150_000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    task automatic wait_for(input int which, input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (which == 0 && recovering)    return;
            if (which == 1 && recovery_done) return;
            if (which == 2 && err_count == 8'd4) return;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset grant", host_grant, 0);
        check("R1", "reset scl_oe", scl_oe, 0);
        check("R1", "reset failed", recovery_failed, 0);
        check("R1", "reset errs", err_count, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R2", "idle ready", bus_ready, 1);

        // Healthy transfer with host pulls passed through.
        host_req = 1'b1;
        @(negedge clk);
        check("R3", "grant rises", host_grant, 1);
        for (int k = 0; k < 8; k++) begin
            host_scl_oe = k[0]; host_sda_oe = k[1];
            #1;
            check("R4", "scl pass", scl_oe, k[0]);
            check("R4", "sda pass", sda_oe, k[1]);
            @(negedge clk);
        end
        host_scl_oe = 1'b0; host_sda_oe = 1'b0; host_req = 1'b0;
        @(negedge clk);
        check("R3", "grant falls", host_grant, 0);

        // Short SDA low below the debounce: no recovery.
        repeat (5) @(negedge clk);
        tgt_stuck = 1'b1;
        repeat (T_DEB - 10) @(negedge clk);
        tgt_stuck = 1'b0;
        repeat (10) @(negedge clk);
        check("R5", "short low ignored", recovering, 0);

        // SDA low while SCL is low: not a hang.
        force_scl_low = 1'b1; tgt_stuck = 1'b1;
        repeat (3 * T_DEB) @(negedge clk);
        check("R5", "scl low no hang", recovering, 0);
        force_scl_low = 1'b0; tgt_stuck = 1'b0;
        repeat (10) @(negedge clk);

        // Healing hang with a host request waiting.
        heal = 1'b1; tgt_stuck = 1'b1;
        repeat (10) @(negedge clk);
        host_req = 1'b1;
        wait_for(0, 3 * T_DEB);
        check("R5", "hang declared", recovering, 1);
        check("R9", "grant held off", host_grant, 0);
        wait_for(1, 2 * T_HOLD);
        check("R7", "done pulse", recovery_done, 1);
        check("R9", "no grant on done", host_grant, 0);
        check("R2", "ready on done", bus_ready, 1);
        check("R8", "no fail on heal", recovery_failed, 0);
        check("R6", "hold length", last_run, T_HOLD);
        @(negedge clk);
        check("R7", "done one cycle", recovery_done, 0);
        check("R3", "grant after done", host_grant, 1);
        host_req = 1'b0; tgt_stuck = 1'b0; heal = 1'b0;
        repeat (10) @(negedge clk);

        // Target that never lets go: all retries fail.
        tgt_stuck = 1'b1;
        wait_for(2, 6 * (T_HOLD + T_SET) + 4 * T_DEB);
        check("R8", "errs after retries", err_count, 4);
        check("R8", "failed set", recovery_failed, 1);
        check("R8", "gives up", recovering, 0);
        tgt_stuck = 1'b0;
        repeat (200) @(negedge clk);
        check("R8", "failed sticky", recovery_failed, 1);
        check("R8", "errs kept", err_count, 4);
        check("R2", "ready again", bus_ready, 1);

        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "reset clears failed", recovery_failed, 0);
        check("R1", "reset clears errs", err_count, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        finish_up();
    end
endmodule